// File: doc/BRIEF.md
# Packed Negated Multiply-Subtract Operand Steering Unit

This unit sits in front of a double-precision fused multiply-add datapath. It takes one packed negated multiply-subtract operation per cycle. Each operation carries an opcode byte, a vector-length flag and three 256-bit register values. The unit decodes which of three operand orderings the opcode selects. It steers the destination, second-source and third-source lanes onto a multiplicand bus, a multiplier bus and a subtrahend bus. It also tells the datapath to negate both the product and the addend, so that each lane computes (-a*b) + (-c) with a single rounding at the end.

The steered operands appear one clock after they are accepted, together with `valid_out`. The datapath returns one 64-bit result per lane on `lane_res` in that same cycle. The unit merges those results into the 256-bit writeback value combinationally. In the narrow form, the upper half of the writeback is forced to zero. An unrecognised opcode produces no lane activity and returns the destination unchanged.

There is no back-pressure. The unit accepts an operation on every cycle where `valid_in` is high. The consumer must take every cycle where `valid_out` is high, and must present `lane_res` in that same cycle.

Top module: `fnms_steer`

## Requirements
- R1: Opcode 8'h9E drives each enabled lane i (bits [64i+63:64i]) with multiplicand = destination, multiplier = third source, subtrahend = second source.
- R2: Opcode 8'hAE drives each enabled lane with multiplicand = second source, multiplier = destination, subtrahend = third source.
- R3: Opcode 8'hBE drives each enabled lane with multiplicand = second source, multiplier = third source, subtrahend = destination.
- R4: With `vl_256`=1 and a legal opcode, `lane_en` is 4'b1111, and writeback lane i equals `lane_res` lane i for all four lanes.
- R5: With `vl_256`=0 and a legal opcode, `lane_en` is 4'b0011. Operand buses in lanes 2 and 3 are zero, and writeback bits 255:128 are zero.
- R6: For a legal opcode, `sign_ctrl` is 2'b11 (bit 1 negates the product, bit 0 negates the addend). For an illegal opcode it is 2'b00.
- R7: Any other opcode sets `illegal_op`, clears `lane_en` and all operand buses, and makes `wb_data` equal to the full 256-bit destination, whatever the vector length.
- R8: `valid_out` is `valid_in` delayed by exactly one clock, and the outputs in that cycle belong to that operation.
- R9: A synchronous active-high `rst` clears `valid_out` on the next edge, even while `valid_in` is high.
- R10: Operations issued on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation present on the input buses |
| opcode | input | 8 | Operation byte selecting the operand ordering |
| vl_256 | input | 1 | 1 = four-lane form, 0 = two-lane form |
| dest_in | input | 256 | Destination register, also the first source |
| src2_in | input | 256 | Second source register |
| src3_in | input | 256 | Third source register |
| valid_out | output | 1 | Steered operands and writeback valid |
| mul_a | output | 256 | Per-lane multiplicand |
| mul_b | output | 256 | Per-lane multiplier |
| sub_c | output | 256 | Per-lane subtrahend |
| lane_en | output | 4 | Lanes the datapath must compute |
| sign_ctrl | output | 2 | Bit 1 negate product, bit 0 negate addend |
| illegal_op | output | 1 | Opcode not recognised |
| lane_res | input | 256 | Per-lane results from the datapath |
| wb_data | output | 256 | Merged 256-bit writeback value |

## Verification
If the stored ordering select were wrong, one cycle after issue a lane would show the wrong source on the multiplicand, multiplier or subtrahend bus. The merged writeback would then differ from a model computed from the inputs. A corrupted enable or illegal flag would show in that same cycle, as nonzero upper writeback bits in the narrow form or as a destination that fails to come back unchanged. The stand-in lane results are a distinct integer function of each operand triple, so swapping two sources changes the writeback value and not only the operand buses.

// File: rtl/fnms_pkg.sv
package fnms_pkg;

  localparam logic [7:0] OPC_F132 = 8'h9E;
  localparam logic [7:0] OPC_F213 = 8'hAE;
  localparam logic [7:0] OPC_F231 = 8'hBE;

  typedef enum logic [1:0] {
    ORD_NONE = 2'd0,
    ORD_132  = 2'd1,
    ORD_213  = 2'd2,
    ORD_231  = 2'd3
  } order_e;

  function automatic order_e order_of(input logic [7:0] op);
    case (op)
      OPC_F132: order_of = ORD_132;
      OPC_F213: order_of = ORD_213;
      OPC_F231: order_of = ORD_231;
      default:  order_of = ORD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fnms_decode.sv
module fnms_decode
  import fnms_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [7:0]       opcode,
  input  logic             vl_256,
  output order_e           order,
  output logic             illegal,
  output logic [LANES-1:0] lane_en,
  output logic [1:0]       sign_ctrl
);
  localparam int HALF = LANES / 2;

  always_comb begin
    order     = order_of(opcode);
    illegal   = (order == ORD_NONE);
    sign_ctrl = illegal ? 2'b00 : 2'b11;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_en
    assign lane_en[i] = !illegal && (vl_256 || (i < HALF));
  end
endmodule

// File: rtl/fnms_lane_mux.sv
module fnms_lane_mux
  import fnms_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  order_e            order,
  input  logic              en,
  input  logic [LANE_W-1:0] d,
  input  logic [LANE_W-1:0] s2,
  input  logic [LANE_W-1:0] s3,
  output logic [LANE_W-1:0] a,
  output logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] c
);
  always_comb begin
    a = '0;
    b = '0;
    c = '0;
    if (en) begin
      case (order)
        ORD_132: begin a = d;  b = s3; c = s2; end
        ORD_213: begin a = s2; b = d;  c = s3; end
        ORD_231: begin a = s2; b = s3; c = d;  end
        default: begin a = '0; b = '0; c = '0; end
      endcase
    end
  end
endmodule

// File: rtl/fnms_merge.sv
module fnms_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 64
) (
  input  logic                    illegal,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] dest,
  input  logic [LANES*LANE_W-1:0] res,
  output logic [LANES*LANE_W-1:0] wb
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LO = i * LANE_W;
    assign wb[LO +: LANE_W] = illegal    ? dest[LO +: LANE_W] :
                              lane_en[i] ? res[LO +: LANE_W]  : '0;
  end
endmodule

// File: rtl/fnms_steer.sv
module fnms_steer
  import fnms_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_in,
  input  logic [7:0]              opcode,
  input  logic                    vl_256,
  input  logic [LANES*LANE_W-1:0] dest_in,
  input  logic [LANES*LANE_W-1:0] src2_in,
  input  logic [LANES*LANE_W-1:0] src3_in,
  output logic                    valid_out,
  output logic [LANES*LANE_W-1:0] mul_a,
  output logic [LANES*LANE_W-1:0] mul_b,
  output logic [LANES*LANE_W-1:0] sub_c,
  output logic [LANES-1:0]        lane_en,
  output logic [1:0]              sign_ctrl,
  output logic                    illegal_op,
  input  logic [LANES*LANE_W-1:0] lane_res,
  output logic [LANES*LANE_W-1:0] wb_data
);
  localparam int VEC_W = LANES * LANE_W;
  localparam int HALF  = LANES / 2;
  localparam logic [LANES-1:0] NARROW_MASK = {{(LANES-HALF){1'b0}}, {HALF{1'b1}}};

  order_e             dec_order;
  logic               dec_illegal;
  logic [LANES-1:0]   dec_en;
  logic [1:0]         dec_sign;
  logic [VEC_W-1:0]   nxt_a, nxt_b, nxt_c;

  logic               valid_q;
  logic [VEC_W-1:0]   a_q, b_q, c_q, dest_q;
  logic [LANES-1:0]   en_q;
  logic [1:0]         sign_q;
  logic               ill_q;

  fnms_decode #(.LANES(LANES)) u_dec (
    .opcode    (opcode),
    .vl_256    (vl_256),
    .order     (dec_order),
    .illegal   (dec_illegal),
    .lane_en   (dec_en),
    .sign_ctrl (dec_sign)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_mux
    fnms_lane_mux #(.LANE_W(LANE_W)) u_mux (
      .order (dec_order),
      .en    (dec_en[i]),
      .d     (dest_in[i*LANE_W +: LANE_W]),
      .s2    (src2_in[i*LANE_W +: LANE_W]),
      .s3    (src3_in[i*LANE_W +: LANE_W]),
      .a     (nxt_a[i*LANE_W +: LANE_W]),
      .b     (nxt_b[i*LANE_W +: LANE_W]),
      .c     (nxt_c[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_in;
  end

  always_ff @(posedge clk) begin
    if (valid_in) begin
      a_q    <= nxt_a;
      b_q    <= nxt_b;
      c_q    <= nxt_c;
      dest_q <= dest_in;
      en_q   <= dec_en;
      sign_q <= dec_sign;
      ill_q  <= dec_illegal;
    end
  end

  fnms_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .illegal (ill_q),
    .lane_en (en_q),
    .dest    (dest_q),
    .res     (lane_res),
    .wb      (wb_data)
  );

  assign valid_out  = valid_q;
  assign mul_a      = a_q;
  assign mul_b      = b_q;
  assign sub_c      = c_q;
  assign lane_en    = en_q;
  assign sign_ctrl  = sign_q;
  assign illegal_op = ill_q;

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  // R8
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  // R1
  order132_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in && opcode == OPC_F132 |=>
      mul_a[LANE_W-1:0] == $past(dest_in[LANE_W-1:0]) &&
      sub_c[LANE_W-1:0] == $past(src2_in[LANE_W-1:0]));
  // R2
  order213_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in && opcode == OPC_F213 |=>
      mul_b[LANE_W-1:0] == $past(dest_in[LANE_W-1:0]) &&
      sub_c[LANE_W-1:0] == $past(src3_in[LANE_W-1:0]));
  // R3
  order231_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in && opcode == OPC_F231 |=>
      sub_c[LANE_W-1:0] == $past(dest_in[LANE_W-1:0]) &&
      mul_a[LANE_W-1:0] == $past(src2_in[LANE_W-1:0]));
  // R4
  wide_mask_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out && !illegal_op && lane_en[LANES-1] |-> lane_en == {LANES{1'b1}});
  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out && !illegal_op && !lane_en[LANES-1] |->
      lane_en == NARROW_MASK && wb_data[VEC_W-1:VEC_W/2] == '0);
  // R6
  sign_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> ((sign_ctrl == 2'b11) != illegal_op));
  // R7
  illegal_pass_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> !illegal_op || (lane_en == '0 && mul_a == '0 &&
      wb_data == $past(dest_in)));
endmodule

// File: tb/fnms_steer_tb.sv
module fnms_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int LANE_W = 64;
  localparam int VEC_W  = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             valid_in = 1'b0;
  logic [7:0]       opcode = '0;
  logic             vl_256 = 1'b0;
  logic [VEC_W-1:0] dest_in = '0, src2_in = '0, src3_in = '0;
  logic             valid_out;
  logic [VEC_W-1:0] mul_a, mul_b, sub_c, lane_res, wb_data;
  logic [LANES-1:0] lane_en;
  logic [1:0]       sign_ctrl;
  logic             illegal_op;

  int n_chk = 0;
  int n_fail = 0;
  int n_in = 0;
  int n_out = 0;

  typedef struct {
    logic [VEC_W-1:0] a, b, c, wb;
    logic [LANES-1:0] en;
    logic [1:0]       sign;
    logic             ill;
    string            tag_op;
    string            tag_vl;
  } item_t;

  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fnms_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .opcode(opcode), .vl_256(vl_256),
    .dest_in(dest_in), .src2_in(src2_in), .src3_in(src3_in),
    .valid_out(valid_out), .mul_a(mul_a), .mul_b(mul_b), .sub_c(sub_c),
    .lane_en(lane_en), .sign_ctrl(sign_ctrl), .illegal_op(illegal_op),
    .lane_res(lane_res), .wb_data(wb_data)
  );

  // Integer stand-in for the fused datapath: -(a*b) - c per lane.
  function automatic logic [LANE_W-1:0] standin(input logic [LANE_W-1:0] a,
      input logic [LANE_W-1:0] b, input logic [LANE_W-1:0] c);
    logic [LANE_W-1:0] p;
    p = a * b;
    return (~p + 1'b1) - c;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_dp
    assign lane_res[i*LANE_W +: LANE_W] =
      standin(mul_a[i*LANE_W +: LANE_W], mul_b[i*LANE_W +: LANE_W], sub_c[i*LANE_W +: LANE_W]);
  end

  task automatic check(input bit ok, input string req, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] rnd256();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < VEC_W/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic drive(input logic [7:0] op, input logic vl,
                       input logic [VEC_W-1:0] d, input logic [VEC_W-1:0] s2,
                       input logic [VEC_W-1:0] s3, input string tag_op);
    item_t it;
    logic legal;
    legal = (op == 8'h9E) || (op == 8'hAE) || (op == 8'hBE);
    it.ill = !legal;
    it.sign = legal ? 2'b11 : 2'b00;
    it.tag_op = tag_op;
    it.tag_vl = vl ? "R4" : "R5";
    for (int i = 0; i < LANES; i++) begin
      logic [LANE_W-1:0] dl, l2, l3, a, b, c;
      logic en;
      dl = d[i*LANE_W +: LANE_W];
      l2 = s2[i*LANE_W +: LANE_W];
      l3 = s3[i*LANE_W +: LANE_W];
      en = legal && (vl || i < 2);
      a = '0; b = '0; c = '0;
      if (en) begin
        if (op == 8'h9E)      begin a = dl; b = l3; c = l2; end
        else if (op == 8'hAE) begin a = l2; b = dl; c = l3; end
        else                  begin a = l2; b = l3; c = dl; end
      end
      it.en[i] = en;
      it.a[i*LANE_W +: LANE_W] = a;
      it.b[i*LANE_W +: LANE_W] = b;
      it.c[i*LANE_W +: LANE_W] = c;
      it.wb[i*LANE_W +: LANE_W] = !legal ? dl : (en ? standin(a, b, c) : '0);
    end
    @(negedge clk);
    valid_in = 1'b1;
    opcode = op;
    vl_256 = vl;
    dest_in = d;
    src2_in = s2;
    src3_in = s3;
    sb_q.push_back(it);
    n_in++;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      n_out++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R8 unexpected valid_out", 256'd1, 256'd0);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        check(mul_a == e.a, {e.tag_op, " mul_a"}, mul_a, e.a);
        check(mul_b == e.b, {e.tag_op, " mul_b"}, mul_b, e.b);
        check(sub_c == e.c, {e.tag_op, " sub_c"}, sub_c, e.c);
        check(lane_en == e.en, {e.tag_vl, " lane_en"}, VEC_W'(lane_en), VEC_W'(e.en));
        check(sign_ctrl == e.sign, "R6 sign_ctrl", VEC_W'(sign_ctrl), VEC_W'(e.sign));
        check(illegal_op == e.ill, "R7 illegal_op", VEC_W'(illegal_op), VEC_W'(e.ill));
        check(wb_data == e.wb, {e.tag_op, "/", e.tag_vl, " wb_data"}, wb_data, e.wb);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog", 256'd0, 256'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(valid_out == 1'b0, "R9 valid_out in reset", VEC_W'(valid_out), 256'd0);
    rst = 1'b0;

    // R1..R5, R10: all orderings, both lengths, back to back
    drive(8'h9E, 1'b1, rnd256(), rnd256(), rnd256(), "R1");
    drive(8'h9E, 1'b0, rnd256(), rnd256(), rnd256(), "R1");
    drive(8'hAE, 1'b1, rnd256(), rnd256(), rnd256(), "R2");
    drive(8'hAE, 1'b0, rnd256(), rnd256(), rnd256(), "R2");
    drive(8'hBE, 1'b1, rnd256(), rnd256(), rnd256(), "R3");
    drive(8'hBE, 1'b0, rnd256(), rnd256(), rnd256(), "R3");
    // R7: illegal opcodes, full destination returned in both lengths
    drive(8'h9F, 1'b1, rnd256(), rnd256(), rnd256(), "R7");
    drive(8'h00, 1'b0, rnd256(), rnd256(), rnd256(), "R7");
    // Structured patterns: each source a distinct constant per lane
    drive(8'hBE, 1'b1, {4{64'h1111_0000_0000_0001}}, {4{64'h2222_0000_0000_0002}},
          {4{64'h3333_0000_0000_0003}}, "R3");
    drive(8'h9E, 1'b0, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'h0}}, {4{64'h5}}, "R1");
    idle();
    @(negedge clk);
    // R8: no operation issued, no valid_out one cycle later
    check(valid_out == 1'b0, "R8 idle valid_out", VEC_W'(valid_out), 256'd0);

    for (int k = 0; k < 24; k++) begin
      logic [7:0] op;
      case (k % 4)
        0: op = 8'h9E;
        1: op = 8'hAE;
        2: op = 8'hBE;
        default: op = 8'(k * 13);
      endcase
      drive(op, k[1], rnd256(), rnd256(), rnd256(),
            op == 8'h9E ? "R1" : op == 8'hAE ? "R2" : op == 8'hBE ? "R3" : "R7");
    end
    idle();
    @(negedge clk);

    // R9: reset while valid_in is high clears valid_out
    rst = 1'b1;
    valid_in = 1'b1;
    opcode = 8'hAE;
    @(negedge clk);
    check(valid_out == 1'b0, "R9 reset with valid_in", VEC_W'(valid_out), 256'd0);
    valid_in = 1'b0;
    rst = 1'b0;
    drive(8'hAE, 1'b1, rnd256(), rnd256(), rnd256(), "R2");
    idle();
    repeat (2) @(negedge clk);

    // R10: every issued operation came back, in order
    check(n_out == n_in && sb_q.size() == 0, "R10 result count",
          VEC_W'(n_out), VEC_W'(n_in));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule